// File: doc/BRIEF.md
# Audio Serial Data Buffer Status

This block is the word staging stage between a processor bus and the serial shift register of an audio port. It holds one received word waiting to be read and one word waiting to be transmitted. It keeps a data-request flag whose meaning follows the port direction. In receive mode the flag means "a word is waiting to be read". In transmit mode it means "the buffer is empty and needs a word". The block also tracks a 2-bit channel number that follows the audio channels word by word.

Software enables the port, picks the direction and the number of channels, and then either polls the flag or enables the interrupt. The shift register side reports two events with single-cycle pulses: a complete word has arrived, or the staged transmit word has been taken. The channel number moves on at each of these events, whether or not software has serviced the buffer. Two sticky error bits record words lost on receive (overrun) and words sent again on transmit (underrun).

Top module: `audio_buf_stat`

## Requirements
- R1: After reset `status` and `irq` are 0, `rx_data` is 0 and `tx_word` is 0 (receive mode selected).
- R2: In receive mode, a `sr_rx_done` pulse stores `sr_rx_word` into `rx_data` and sets the data-request flag (`status[24]`). A `rd_rx` pulse with no word arriving in the same cycle clears the flag.
- R3: In transmit mode the flag is 1 while the transmit buffer is empty. A `wr_tx` pulse stores `tx_wdata`, presented on `tx_word`, and clears the flag. An `sr_tx_load` pulse sets the flag again.
- R4: `irq` is 1 exactly when the flag and `irq_en` are both 1. Changing `irq_en` never changes the flag.
- R5: A status write (`wr_stat`) has no effect on the flag, whatever value is written to bit 24.
- R6: In receive mode `status[3:2]` holds the channel of the word in `rx_data`. The k-th word received since enable (k from 0) belongs to channel k mod N, where N = `chan_lim` + 1.
- R7: In transmit mode `status[3:2]` is the channel of the next word to supply. It equals (number of loads since enable) mod N and advances on every load, even when no word was written.
- R8: A load while the transmit buffer is empty leaves `tx_word` unchanged, so the previous word is sent again, and sets the sticky underrun bit `status[4]`.
- R9: A received word that arrives while the previous one is unread, and is not being read in the same cycle, overwrites `rx_data` and sets the sticky overrun bit `status[5]`.
- R10: A status write with bit 4 or bit 5 set to 1 clears that error bit. A new error in the same cycle wins over the clear.
- R11: With `port_en` low, both buffers are empty, the channel number is 0 and bus writes to the transmit buffer are ignored. A change of `tx_mode` resets the channel number to 0.
- R12: All status bits other than 24, 5, 4, 3 and 2 read as 0.
- R13: Shift-register events for the direction that is not selected (`sr_tx_load` in receive mode, `sr_rx_done` in transmit mode) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low empties buffers and zeroes the channel |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| chan_lim | input | 2 | Number of channels minus one |
| irq_en | input | 1 | Interrupt enable |
| rd_rx | input | 1 | Bus read strobe of the receive word |
| wr_tx | input | 1 | Bus write strobe of the transmit word |
| tx_wdata | input | DATA_W | Bus write data for the transmit word |
| wr_stat | input | 1 | Bus write strobe of the status word |
| stat_wdata | input | 32 | Status write data (1 in bit 4/5 clears that error) |
| sr_rx_done | input | 1 | Pulse: shift register completed a received word |
| sr_rx_word | input | DATA_W | Word from the shift register |
| sr_tx_load | input | 1 | Pulse: shift register copies the transmit word |
| rx_data | output | DATA_W | Receive word for the bus |
| tx_word | output | DATA_W | Staged transmit word for the shift register |
| status | output | 32 | Flag bit 24, overrun bit 5, underrun bit 4, channel bits 3:2 |
| irq | output | 1 | Data-request interrupt |

## Verification
A wrong full state shows on `status[24]` and `irq` one cycle after the event that should have set or cleared it. A wrong channel counter shows in `status[3:2]` at the next event, and the bench checks it after every word for each channel count from 1 to 4. A word lost or sent again by mistake shows on `rx_data` or `tx_word` straight after the edge of the event. A missing error report shows in bit 5 or bit 4 in that same cycle.

// File: rtl/audio_buf_pkg.sv
package audio_buf_pkg;
  localparam int STAT_W    = 32;
  localparam int FLAG_BIT  = 24;
  localparam int OVR_BIT   = 5;
  localparam int UND_BIT   = 4;
  localparam int CH_LSB    = 2;
  localparam int CH_W      = 2;
endpackage

// File: rtl/abs_rx_stage.sv
module abs_rx_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              rx_evt,
  input  logic              rd_evt,
  input  logic [DATA_W-1:0] word_in,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr
);
  logic [DATA_W-1:0] data_d;
  logic              full_d;
  logic              ovr_d;

  always_comb begin
    data_d = rx_data;
    full_d = rx_full;
    ovr_d  = clr_ovr ? 1'b0 : ovr;
    if (!port_en) begin
      full_d = 1'b0;
    end else if (rx_evt) begin
      data_d = word_in;
      full_d = 1'b1;
      if (rx_full && !rd_evt) ovr_d = 1'b1;
    end else if (rd_evt) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      rx_data <= data_d;
      rx_full <= full_d;
      ovr     <= ovr_d;
    end
  end

  assert_rx_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rx_evt) |=> (rx_full && rx_data == $past(word_in)));
  assert_rx_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rd_evt && !rx_evt) |=> !rx_full);
  assert_rx_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rx_evt && rx_full && !rd_evt) |=> ovr);
endmodule

// File: rtl/abs_tx_stage.sv
module abs_tx_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_evt,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_und,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_full,
  output logic              und
);
  logic [DATA_W-1:0] word_d;
  logic              full_d;
  logic              und_d;

  always_comb begin
    word_d = tx_word;
    full_d = tx_full;
    und_d  = clr_und ? 1'b0 : und;
    if (!port_en) begin
      full_d = 1'b0;
    end else begin
      if (tx_evt) begin
        full_d = 1'b0;
        if (!tx_full) und_d = 1'b1;
      end
      if (wr_evt) begin
        word_d = wdata;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_full <= 1'b0;
      und     <= 1'b0;
    end else begin
      tx_word <= word_d;
      tx_full <= full_d;
      und     <= und_d;
    end
  end

  assert_tx_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_evt) |=> (tx_full && tx_word == $past(wdata)));
  assert_tx_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && tx_evt && !wr_evt) |=> !tx_full);
  assert_tx_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && tx_evt && !tx_full && !wr_evt) |=> ($stable(tx_word) && und));
  assert_tx_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !tx_full);
endmodule

// File: rtl/abs_chan_track.sv
module abs_chan_track #(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic            tx_mode,
  input  logic [CH_W-1:0] chan_lim,
  input  logic            rx_evt,
  input  logic            tx_evt,
  output logic [CH_W-1:0] chan
);
  logic [CH_W-1:0] cnt, cnt_d, cnt_inc;
  logic [CH_W-1:0] rx_ch, rx_ch_d;
  logic            mode_q;
  logic            restart;

  always_comb begin
    restart = !port_en || (tx_mode != mode_q);
    cnt_inc = (cnt >= chan_lim) ? '0 : cnt + 1'b1;
    cnt_d   = cnt;
    rx_ch_d = rx_ch;
    if (restart) begin
      cnt_d   = '0;
      rx_ch_d = '0;
    end else if (rx_evt) begin
      rx_ch_d = cnt;
      cnt_d   = cnt_inc;
    end else if (tx_evt) begin
      cnt_d   = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rx_ch  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      rx_ch  <= rx_ch_d;
      mode_q <= tx_mode;
    end
  end

  assign chan = tx_mode ? cnt : rx_ch;

  assert_chan_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (cnt == '0 && rx_ch == '0));
  assert_rx_chan_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && !restart) |=> (rx_ch == $past(cnt)));
  assert_tx_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_evt && !tx_evt && !restart) |=> $stable(cnt));
endmodule

// File: rtl/audio_buf_stat.sv
module audio_buf_stat
  import audio_buf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_mode,
  input  logic [1:0]        chan_lim,
  input  logic              irq_en,
  input  logic              rd_rx,
  input  logic              wr_tx,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              wr_stat,
  input  logic [31:0]       stat_wdata,
  input  logic              sr_rx_done,
  input  logic [DATA_W-1:0] sr_rx_word,
  input  logic              sr_tx_load,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] tx_word,
  output logic [31:0]       status,
  output logic              irq
);
  logic            rx_evt, tx_evt;
  logic            rx_full, tx_full, ovr, und, flag;
  logic            clr_ovr, clr_und;
  logic [CH_W-1:0] chan;

  assign rx_evt  = port_en && !tx_mode && sr_rx_done;
  assign tx_evt  = port_en && tx_mode && sr_tx_load;
  assign clr_ovr = wr_stat && stat_wdata[OVR_BIT];
  assign clr_und = wr_stat && stat_wdata[UND_BIT];

  abs_rx_stage #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_evt(rx_evt),
    .rd_evt(rd_rx), .word_in(sr_rx_word), .clr_ovr(clr_ovr),
    .rx_data(rx_data), .rx_full(rx_full), .ovr(ovr)
  );

  abs_tx_stage #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_evt(tx_evt),
    .wr_evt(wr_tx), .wdata(tx_wdata), .clr_und(clr_und),
    .tx_word(tx_word), .tx_full(tx_full), .und(und)
  );

  abs_chan_track #(.CH_W(CH_W)) ch_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_mode(tx_mode),
    .chan_lim(chan_lim), .rx_evt(rx_evt), .tx_evt(tx_evt), .chan(chan)
  );

  always_comb begin
    flag   = tx_mode ? !tx_full : rx_full;
    status = '0;
    status[FLAG_BIT]              = flag;
    status[OVR_BIT]               = ovr;
    status[UND_BIT]               = und;
    status[CH_LSB +: CH_W]        = chan;
    irq    = flag && irq_en;
  end

  assert_stat_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && port_en && !rx_evt && !tx_evt && !rd_rx && !wr_tx)
      |=> ($stable(rx_full) && $stable(tx_full)));
  assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !rx_evt) |=> !status[OVR_BIT]);
  assert_und_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_und && !tx_evt) |=> !status[UND_BIT]);
endmodule

// File: tb/audio_buf_stat_tb_top.sv
module audio_buf_stat_tb_top;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n, port_en, tx_mode, irq_en, rd_rx, wr_tx, wr_stat;
  logic sr_rx_done, sr_tx_load;
  logic [1:0] chan_lim;
  logic [W-1:0] tx_wdata, sr_rx_word, rx_data, tx_word;
  logic [31:0] stat_wdata, status;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  audio_buf_stat #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_mode(tx_mode),
    .chan_lim(chan_lim), .irq_en(irq_en), .rd_rx(rd_rx), .wr_tx(wr_tx),
    .tx_wdata(tx_wdata), .wr_stat(wr_stat), .stat_wdata(stat_wdata),
    .sr_rx_done(sr_rx_done), .sr_rx_word(sr_rx_word), .sr_tx_load(sr_tx_load),
    .rx_data(rx_data), .tx_word(tx_word), .status(status), .irq(irq)
  );

  function automatic logic [31:0] mk(bit f, bit o, bit u, int ch);
    logic [1:0] c = 2'(ch);
    return (32'(f) << 24) | (32'(o) << 5) | (32'(u) << 4) | (32'(c) << 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask
  task automatic rx_in(logic [W-1:0] w);
    sr_rx_word = w; sr_rx_done = 1; tick; sr_rx_done = 0;
  endtask
  task automatic rd; rd_rx = 1; tick; rd_rx = 0; endtask
  task automatic wr(logic [W-1:0] w);
    tx_wdata = w; wr_tx = 1; tick; wr_tx = 0;
  endtask
  task automatic ld; sr_tx_load = 1; tick; sr_tx_load = 0; endtask
  task automatic swr(logic [31:0] v);
    stat_wdata = v; wr_stat = 1; tick; wr_stat = 0;
  endtask
  task automatic recycle; port_en = 0; tick; port_en = 1; tick; endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; port_en = 0; tx_mode = 0; chan_lim = 0; irq_en = 0;
    rd_rx = 0; wr_tx = 0; wr_stat = 0; sr_rx_done = 0; sr_tx_load = 0;
    tx_wdata = '0; sr_rx_word = '0; stat_wdata = '0;
    tick; tick; tick;
    chk("R1 status", status, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rx_data", 32'(rx_data), 32'h0);
    chk("R1 tx_word", 32'(tx_word), 32'h0);
    rst_n = 1; tick; port_en = 1; tick;

    // R2, R6, R12: receive sweep over every channel count
    for (int n = 1; n <= 4; n++) begin
      chan_lim = 2'(n - 1); recycle;
      for (int i = 0; i <= 2 * n; i++) begin
        logic [W-1:0] w = W'(16'h1000 + n * 64 + i);
        rx_in(w);
        chk("R2 rx_data", 32'(rx_data), 32'(w));
        chk("R6 R12 rx status full", status, mk(1, 0, 0, i % n));
        rd;
        chk("R2 rx status read", status, mk(0, 0, 0, i % n));
      end
    end

    // R9 overrun, R10 clear
    chan_lim = 3; recycle;
    rx_in(16'hAAAA); rx_in(16'hBBBB);
    chk("R9 overwrite", 32'(rx_data), 32'h0000BBBB);
    chk("R9 overrun bit", status, mk(1, 1, 0, 1));
    swr(32'h0000_0020);
    chk("R10 overrun cleared", status, mk(1, 0, 0, 1));

    // R4 interrupt masking, R5 status write
    irq_en = 1; #1;
    chk("R4 irq flag set", 32'(irq), 32'h1);
    irq_en = 0; #1;
    chk("R4 irq masked", 32'(irq), 32'h0);
    chk("R4 flag kept", status, mk(1, 0, 0, 1));
    swr(32'h0);
    chk("R5 zero write", status, mk(1, 0, 0, 1));
    rd; irq_en = 1; #1;
    chk("R4 irq flag clear", 32'(irq), 32'h0);
    irq_en = 0;

    // R13 wrong-direction load in receive mode
    ld;
    chk("R13 load ignored rx", status, mk(0, 0, 0, 1));
    chk("R13 tx_word kept", 32'(tx_word), 32'h0);

    // R11 mode change resets channel
    tx_mode = 1; tick;
    chk("R11 mode change", status, mk(1, 0, 0, 0));

    // R3, R7: transmit sweep
    for (int n = 1; n <= 4; n++) begin
      chan_lim = 2'(n - 1); recycle;
      for (int i = 0; i <= 2 * n; i++) begin
        logic [W-1:0] w = W'(16'h5000 + n * 64 + i);
        chk("R7 chan before write", status, mk(1, 0, 0, i % n));
        wr(w);
        chk("R3 full after write", status, mk(0, 0, 0, i % n));
        ld;
        chk("R3 tx_word", 32'(tx_word), 32'(w));
        chk("R3 R7 empty after load", status, mk(1, 0, 0, (i + 1) % n));
      end
    end

    // R8 underrun and R7 advance without a write
    chan_lim = 3; recycle;
    wr(16'hC0DE); ld;
    ld;
    chk("R8 resend", 32'(tx_word), 32'h0000C0DE);
    chk("R8 R7 underrun", status, mk(1, 0, 1, 2));
    swr(32'h0100_0000);
    chk("R5 write one flag", status, mk(1, 0, 1, 2));
    swr(32'h0000_0010);
    chk("R10 underrun cleared", status, mk(1, 0, 0, 2));

    // R13 wrong-direction receive in transmit mode
    rx_in(16'h7777);
    chk("R13 rx ignored tx", 32'(rx_data), 32'h0000BBBB);
    chk("R13 status kept", status, mk(1, 0, 0, 2));

    // R11 disable empties and zeroes
    wr(16'h1234);
    chk("R3 full before disable", status, mk(0, 0, 0, 2));
    port_en = 0; tick;
    chk("R11 disable", status, mk(1, 0, 0, 0));
    wr(16'h4321);
    chk("R11 write ignored", 32'(tx_word), 32'h00001234);
    port_en = 1; tick; ld;
    tx_mode = 0; tick;
    chk("R11 back to rx", status, mk(0, 0, 1, 0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule